// File: doc/BRIEF.md
# Status-Register Write Guard for a Serial EEPROM

This block holds the protection state of a serial EEPROM status register and decides, in the same cycle, whether each incoming write request may proceed. There are two request paths. A status-register write carries a data byte. An array write carries a byte address. The block grants or denies each request by looking at the external write-enable latch, the level on the write-protect pin and the protection bits it keeps.

The array is treated as four equal segments. A two-bit block-protect field locks nothing, the top quarter, the top half or the whole array. A separate lock-enable bit, combined with a low level on the protect pin, freezes the status register itself. When any write is granted, the block pulses a clear for the external write-enable latch. The protection bits are held in retained registers. Nonvolatile programming time, the serial front end and the array storage are handled elsewhere.

Top module: `eeprom_sr_guard`

## Requirements
- R1: After reset the block-protect field and the lock-enable bit are 0. With the latch input low and no request, the status byte reads 0x00 and every grant, deny and clear output is 0.
- R2: The status byte is laid out as: bit 0 = busy (always 0), bit 1 = the present write-enable latch input, bit 2 = block-protect low bit, bit 3 = block-protect high bit, bit 7 = lock-enable. Bits 4 to 6 read 0.
- R3: The protect level is {bit3, bit2}. Level 0 protects nothing. Level 1 protects addresses whose two top bits are 11 (0x6000-0x7FFF for 15-bit addresses). Level 2 protects addresses whose top bit is 1 (0x4000-0x7FFF). Level 3 protects every address.
- R4: An array write outside the protected range is granted only while the write-enable latch is 1.
- R5: An array write inside the protected range is always denied, whatever the latch or the pin.
- R6: While the protect pin is low and lock-enable is 1, every status write is denied and the stored bits stay unchanged, so lock-enable cannot return to 0.
- R7: With the latch set and the register not locked, a status write is granted. Bits 2, 3 and 7 of the data byte are stored at the next clock edge. The other data bits have no effect.
- R8: The latch-clear output is 1 in exactly the cycles in which a write (to the array or the status register) is granted.
- R9: While the latch is 0, status writes are denied whatever the pin or lock-enable bit.
- R10: For each path, deny is 1 exactly when that path requests and is not granted. With no request on a path, neither its grant nor its deny is 1.
- R11: When both paths request in the same cycle, each is judged against the stored bits from before that edge, and both may be granted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the retained bits |
| prot_pin | input | 1 | Write-protect pin level (low requests the hardware lock) |
| wr_en_latch | input | 1 | Current write-enable latch state |
| sr_wr_req | input | 1 | Status-register write request |
| sr_wr_data | input | 8 | Data byte for the status write |
| arr_wr_req | input | 1 | Array write request |
| arr_wr_addr | input | ADDR_W | Byte address of the array write |
| status_byte | output | 8 | Current status byte |
| sr_wr_grant | output | 1 | Status write allowed |
| sr_wr_deny | output | 1 | Status write refused |
| arr_wr_grant | output | 1 | Array write allowed |
| arr_wr_deny | output | 1 | Array write refused |
| latch_clear | output | 1 | Clear the write-enable latch this cycle |

## Verification
A status write and an array write can arrive in the same cycle. A status write that changes the protect level must not affect the judgement of the array write that comes alongside it. The vector table places both requests in one cycle twice. In one case, both writes are granted while the protect level changes from 0 to 1. In the other, the status write lowers the level while the array address falls inside the range that is still protected, so the array write must be denied. The bench reads both grants and the latch clear before the edge and the new status byte after it.

// File: rtl/wguard_pkg.sv
package wguard_pkg;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'd0,
    LVL_QUARTER = 2'd1,
    LVL_HALF    = 2'd2,
    LVL_ALL     = 2'd3
  } prot_lvl_e;

  localparam int SB_BUSY  = 0;
  localparam int SB_LATCH = 1;
  localparam int SB_BPLO  = 2;
  localparam int SB_BPHI  = 3;
  localparam int SB_LOCK  = 7;

  function automatic prot_lvl_e lvl_of(input logic bp_hi, input logic bp_lo);
    return prot_lvl_e'({bp_hi, bp_lo});
  endfunction

  // top2 = two most significant address bits
  function automatic logic addr_locked(input prot_lvl_e lvl, input logic [1:0] top2);
    logic hit;
    unique case (lvl)
      LVL_NONE:    hit = 1'b0;
      LVL_QUARTER: hit = (top2 == 2'b11);
      LVL_HALF:    hit = top2[1];
      default:     hit = 1'b1;
    endcase
    return hit;
  endfunction

  function automatic logic hw_lock_on(input logic pin, input logic lock_en);
    return lock_en & ~pin;
  endfunction

endpackage

// File: rtl/wg_prot_regs.sv
module wg_prot_regs
  import wguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic       bp_hi,
  output logic       bp_lo,
  output logic       lock_en
);
  logic unused_data_bits;
  assign unused_data_bits = ^{wr_data[6:4], wr_data[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_hi   <= 1'b0;
      bp_lo   <= 1'b0;
      lock_en <= 1'b0;
    end else if (wr_stb) begin
      bp_hi   <= wr_data[SB_BPHI];
      bp_lo   <= wr_data[SB_BPLO];
      lock_en <= wr_data[SB_LOCK];
    end
  end

  // R7: bits move only on a granted strobe
  p_hold_without_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable({bp_hi, bp_lo, lock_en}));

  p_load_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ({bp_hi, bp_lo, lock_en} ==
                {$past(wr_data[SB_BPHI]), $past(wr_data[SB_BPLO]), $past(wr_data[SB_LOCK])}));
endmodule

// File: rtl/wg_range_check.sv
module wg_range_check
  import wguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  prot_lvl_e  lvl,
  input  logic [1:0] addr_top,
  output logic       in_range
);
  assign in_range = addr_locked(lvl, addr_top);

  p_none_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_NONE) |-> !in_range);
  p_all_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_ALL) |-> in_range);
  p_quarter_low_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_QUARTER && addr_top != 2'b11) |-> !in_range);
endmodule

// File: rtl/wg_decider.sv
module wg_decider
  import wguard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic latch,
  input  logic hw_lock,
  input  logic in_range,
  input  logic sr_req,
  input  logic arr_req,
  output logic sr_grant,
  output logic sr_deny,
  output logic arr_grant,
  output logic arr_deny,
  output logic clr_latch
);
  logic sr_ok, arr_ok;

  assign sr_ok     = latch & ~hw_lock;
  assign arr_ok    = latch & ~in_range;
  assign sr_grant  = sr_req & sr_ok;
  assign sr_deny   = sr_req & ~sr_ok;
  assign arr_grant = arr_req & arr_ok;
  assign arr_deny  = arr_req & ~arr_ok;
  assign clr_latch = sr_grant | arr_grant;

  p_lock_refuses_sr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |-> !sr_grant);
  p_range_refuses_arr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_range |-> !arr_grant);
  p_no_latch_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |-> (!sr_grant && !arr_grant && !clr_latch));
  p_excl_sr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_grant && sr_deny));
  p_excl_arr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_grant && arr_deny));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_req && !arr_req) |-> !(sr_grant || sr_deny || arr_grant || arr_deny || clr_latch));
endmodule

// File: rtl/eeprom_sr_guard.sv
module eeprom_sr_guard
  import wguard_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_pin,
  input  logic              wr_en_latch,
  input  logic              sr_wr_req,
  input  logic [7:0]        sr_wr_data,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_wr_addr,
  output logic [7:0]        status_byte,
  output logic              sr_wr_grant,
  output logic              sr_wr_deny,
  output logic              arr_wr_grant,
  output logic              arr_wr_deny,
  output logic              latch_clear
);
  localparam int TOP_LO = ADDR_W - 2;

  logic       bp_hi, bp_lo, lock_en;
  logic       hw_lock, in_range;
  prot_lvl_e  lvl;
  logic [1:0] addr_top;
  logic       unused_addr_low;

  assign addr_top        = arr_wr_addr[ADDR_W-1:TOP_LO];
  assign unused_addr_low = ^arr_wr_addr[TOP_LO-1:0];
  assign lvl             = lvl_of(bp_hi, bp_lo);
  assign hw_lock         = hw_lock_on(prot_pin, lock_en);

  wg_prot_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (sr_wr_grant),
    .wr_data (sr_wr_data),
    .bp_hi   (bp_hi),
    .bp_lo   (bp_lo),
    .lock_en (lock_en)
  );

  wg_range_check u_range (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl),
    .addr_top (addr_top),
    .in_range (in_range)
  );

  wg_decider u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch     (wr_en_latch),
    .hw_lock   (hw_lock),
    .in_range  (in_range),
    .sr_req    (sr_wr_req),
    .arr_req   (arr_wr_req),
    .sr_grant  (sr_wr_grant),
    .sr_deny   (sr_wr_deny),
    .arr_grant (arr_wr_grant),
    .arr_deny  (arr_wr_deny),
    .clr_latch (latch_clear)
  );

  always_comb begin
    status_byte           = 8'h00;
    status_byte[SB_BUSY]  = 1'b0;
    status_byte[SB_LATCH] = wr_en_latch;
    status_byte[SB_BPLO]  = bp_lo;
    status_byte[SB_BPHI]  = bp_hi;
    status_byte[SB_LOCK]  = lock_en;
  end

  // R6: lock-enable cannot fall while the pin is low
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_pin && status_byte[SB_LOCK]) |=> status_byte[SB_LOCK]);
  // R2: unused positions stay at zero
  p_spare_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6:4] == 3'b000 && !status_byte[SB_BUSY]);
  // R8: clear pulse only together with a grant
  p_clear_needs_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clear |-> (sr_wr_grant || arr_wr_grant));
endmodule

// File: tb/eeprom_sr_guard_tb_top.sv
module eeprom_sr_guard_tb_top;
  localparam int AW = 15;
  localparam int NV = 16;
  // pin latch srq srd[8] arq addr[16] exp_sg exp_ag exp_status_after[8]
  localparam logic [37:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,8'h00,1'b1,16'h7FFF,1'b0,1'b0,8'h00}, // R4 latch low
    {1'b1,1'b1,1'b0,8'h00,1'b1,16'h7FFF,1'b0,1'b1,8'h00}, // R4 level 0
    {1'b1,1'b1,1'b1,8'h04,1'b0,16'h0000,1'b1,1'b0,8'h04}, // R7 set level 1
    {1'b1,1'b1,1'b0,8'h00,1'b1,16'h6000,1'b0,1'b0,8'h04}, // R3/R5 quarter
    {1'b1,1'b1,1'b0,8'h00,1'b1,16'h5FFF,1'b0,1'b1,8'h04}, // R3 below quarter
    {1'b1,1'b0,1'b1,8'h08,1'b0,16'h0000,1'b0,1'b0,8'h04}, // R9 latch low
    {1'b1,1'b1,1'b1,8'h08,1'b0,16'h0000,1'b1,1'b0,8'h08}, // R7 level 2
    {1'b1,1'b1,1'b0,8'h00,1'b1,16'h4000,1'b0,1'b0,8'h08}, // R3 half
    {1'b1,1'b1,1'b0,8'h00,1'b1,16'h3FFF,1'b0,1'b1,8'h08}, // R3 below half
    {1'b1,1'b1,1'b1,8'h8C,1'b0,16'h0000,1'b1,1'b0,8'h8C}, // R7 lock en, level 3
    {1'b1,1'b1,1'b0,8'h00,1'b1,16'h0000,1'b0,1'b0,8'h8C}, // R3/R5 all
    {1'b0,1'b1,1'b1,8'h00,1'b0,16'h0000,1'b0,1'b0,8'h8C}, // R6 locked
    {1'b0,1'b1,1'b1,8'h00,1'b1,16'h0000,1'b0,1'b0,8'h8C}, // R6/R5 both refused
    {1'b1,1'b1,1'b1,8'h73,1'b0,16'h0000,1'b1,1'b0,8'h00}, // R7 spare bits ignored
    {1'b1,1'b1,1'b1,8'h04,1'b1,16'h7FFF,1'b1,1'b1,8'h04}, // R11 both granted
    {1'b1,1'b1,1'b1,8'h00,1'b1,16'h7000,1'b1,1'b0,8'h00}  // R11 old level used
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prot_pin = 1'b1, wr_en_latch = 1'b0;
  logic          sr_wr_req = 1'b0, arr_wr_req = 1'b0;
  logic [7:0]    sr_wr_data = 8'h00;
  logic [AW-1:0] arr_wr_addr = '0;
  logic [7:0]    status_byte;
  logic          sr_wr_grant, sr_wr_deny, arr_wr_grant, arr_wr_deny, latch_clear;
  int            total = 0, bad = 0;

  always #10 clk = ~clk;

  eeprom_sr_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .prot_pin(prot_pin), .wr_en_latch(wr_en_latch),
    .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data), .arr_wr_req(arr_wr_req),
    .arr_wr_addr(arr_wr_addr), .status_byte(status_byte), .sr_wr_grant(sr_wr_grant),
    .sr_wr_deny(sr_wr_deny), .arr_wr_grant(arr_wr_grant), .arr_wr_deny(arr_wr_deny),
    .latch_clear(latch_clear)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    sr_wr_req = 1'b0; arr_wr_req = 1'b0; wr_en_latch = 1'b0; prot_pin = 1'b1;
  endtask

  initial begin : watchdog
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 status", status_byte, 8'h00);
    chk("R1 outputs", {3'b0, sr_wr_grant, sr_wr_deny, arr_wr_grant, arr_wr_deny, latch_clear}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      logic sg, ag, sq, aq;
      v = VEC[i];
      @(negedge clk);
      prot_pin = v[37]; wr_en_latch = v[36]; sr_wr_req = v[35];
      sr_wr_data = v[34:27]; arr_wr_req = v[26]; arr_wr_addr = v[10+AW-1:10];
      sq = v[35]; aq = v[26]; sg = v[9]; ag = v[8];
      #2;
      chk($sformatf("R4/R5/R6/R9 sr grant v%0d", i), {7'b0, sr_wr_grant}, {7'b0, sg});
      chk($sformatf("R4/R5 arr grant v%0d", i), {7'b0, arr_wr_grant}, {7'b0, ag});
      chk($sformatf("R10 denies v%0d", i), {6'b0, sr_wr_deny, arr_wr_deny},
          {6'b0, sq & ~sg, aq & ~ag});
      chk($sformatf("R8 clear v%0d", i), {7'b0, latch_clear}, {7'b0, sg | ag});
      @(posedge clk); #2;
      idle();
      #1;
      chk($sformatf("R7/R11 status v%0d", i), status_byte, v[7:0]);
    end

    // R2: bit 1 mirrors the latch input without a request
    @(negedge clk); wr_en_latch = 1'b1; #2;
    chk("R2 latch bit", status_byte, 8'h02);
    chk("R10 idle quiet", {3'b0, sr_wr_grant, sr_wr_deny, arr_wr_grant, arr_wr_deny, latch_clear}, 8'h00);
    idle();

    // R6: set lock, drive pin low, attempt to clear lock repeatedly
    @(negedge clk); wr_en_latch = 1'b1; sr_wr_req = 1'b1; sr_wr_data = 8'h80;
    @(posedge clk); #2; idle();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); prot_pin = 1'b0; wr_en_latch = 1'b1; sr_wr_req = 1'b1; sr_wr_data = 8'h00;
      @(posedge clk); #2; idle(); #1;
      chk("R6 lock holds", status_byte, 8'h80);
    end
    // pin high releases the lock
    @(negedge clk); prot_pin = 1'b1; wr_en_latch = 1'b1; sr_wr_req = 1'b1; sr_wr_data = 8'h0C;
    #2; chk("R6 pin high grants", {7'b0, sr_wr_grant}, 8'h01);
    @(posedge clk); #2; idle(); #1;
    chk("R7 after release", status_byte, 8'h0C);

    // R1: reset mid-run clears retained bits
    @(negedge clk); rst_n = 1'b0; #2;
    chk("R1 reset mid-run", status_byte, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); wr_en_latch = 1'b1; arr_wr_req = 1'b1; arr_wr_addr = 15'h7FFF; #2;
    chk("R1 level 0 after reset", {7'b0, arr_wr_grant}, 8'h01);
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule